// File: doc/BRIEF.md
# Double-Buffered Clock Register Interface

This block is the bus-facing side of a battery-backed calendar clock. It sits in a byte-wide memory space and claims the eight highest addresses. All other addresses go straight through to an external RAM port. Each of the eight bytes holds one clock field (control and century, seconds, minutes, hours, weekday, day of month, month, year). The bytes seen on the bus are a separate copy of the running counters, which live in a neighbouring counter block.

When the block is running freely, the copy reloads from the counters on every one-second tick. Software can freeze the copy in two ways:
- Setting the read-hold bit freezes it for a consistent read while the counters keep running.
- Setting the write-hold bit freezes it so that new values can be loaded. Clearing that bit then gives a one-cycle load pulse that carries the loaded values into the counters.

The block also holds an oscillator-stop bit and a frequency-test bit. The frequency-test bit replaces the seconds LSB on reads with a 512 Hz square wave. A read-only battery-good flag comes from a digital input.

A four-state controller drives the behaviour:
- `ST_RUN`: free running, reload on each tick.
- `ST_RHOLD`: read hold.
- `ST_WHOLD`: write hold.
- `ST_COMMIT`: the single load cycle.

The transitions are:
- Run to read-hold: the control byte is written with bit 6 = 1 and bit 7 = 0.
- Run or read-hold to write-hold: the control byte is written with bit 7 = 1.
- Read-hold to run: the control byte is written with both bits 0.
- Write-hold to commit: the control byte is written with bit 7 = 0.
- Commit to read-hold or run: this happens on the next cycle, chosen by the stored read-hold bit. A further control write in that cycle overrides the choice.

Top module: `rtc_regfile`

## Requirements
- R1: Addresses whose upper 16 bits are all ones select the clock bytes, and the low three bits pick the field: 0 control/century, 1 seconds, 2 minutes, 3 hours, 4 weekday, 5 day of month, 6 month, 7 year. Any other address with the chip selected raises `ram_cs`, and a read there returns `ram_rdata`.
- R2: A read happens when `cs_n`=0, `oe_n`=0 and `we_n`=1. A write happens when `cs_n`=0 and `we_n`=0, whatever the value of `oe_n`. With no read in progress, `rdata` is 0.
- R3: In the run state, each `tick` reloads all eight visible bytes from `cnt_in`. Byte i of `cnt_in` is bits 8i+7..8i. A bus write to a byte takes priority over the reload of that byte.
- R4: Writing 1 to control bit 6 (read hold) freezes the visible bytes, and a tick does not change them. Bit 6 reads back as 1, and no load pulse is produced.
- R5: After read hold is cleared, the visible bytes keep their values until the next `tick`, which reloads them.
- R6: Writing 1 to control bit 7 (write hold) freezes the visible bytes against ticks, while bus writes still land. Bit 7 reads back as 1. The cycle after a control write with bit 7 = 0 raises `cnt_load` for exactly one cycle, and `cnt_load_data` then carries the visible bytes in the layout of `cnt_in`.
- R7: Seconds bit 7 drives `osc_stop` and reads back.
- R8: Weekday bit 6 is the frequency-test bit and reads back. While it is 1 and `osc_stop` is 0, seconds bit 0 reads `sq512`.
- R9: Weekday bit 7 always reads `batt_ok`, and writes to it have no effect.
- R10: Bits outside each field read 0. The field masks are: century 0x3F, seconds 0x7F, minutes 0x7F, hours 0x3F, weekday 0x07, day 0x3F, month 0x1F, year 0xFF.
- R11: After reset, every visible byte and control bit is 0, `osc_stop` and `cnt_load` are 0, and the controller is in the run state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | ADDR_W | Byte address |
| wdata | input | 8 | Write data |
| cs_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| rdata | output | 8 | Read data |
| ram_rdata | input | 8 | Data returned by the external RAM |
| ram_cs | output | 1 | External RAM selected |
| ram_we | output | 1 | External RAM write strobe |
| ram_oe | output | 1 | External RAM read strobe |
| tick | input | 1 | One-second pulse from the counter block |
| cnt_in | input | 64 | Running counter bytes |
| cnt_load | output | 1 | Load pulse to the counter block |
| cnt_load_data | output | 64 | Values to load into the counters |
| osc_stop | output | 1 | Oscillator stop request |
| sq512 | input | 1 | 512 Hz square wave |
| batt_ok | input | 1 | Battery-good indication |

## Verification
The assertions assume that each bus strobe is sampled on one clock edge and that `tick` is a one-cycle pulse. They also assume the bus inputs are never unknown after reset. The bench holds every strobe for exactly one cycle, changing it on the falling edge. It pulses `tick` only when no write is being driven and changes `cnt_in` only between ticks. As a result, every freeze and load check sees a single, unambiguous event.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
    localparam int NREG     = 8;
    localparam int BYTE_W   = 8;
    localparam int IDX_W    = $clog2(NREG);
    localparam int IDX_CTRL = 0;
    localparam int IDX_SEC  = 1;
    localparam int IDX_MIN  = 2;
    localparam int IDX_HOUR = 3;
    localparam int IDX_DAY  = 4;
    localparam int IDX_DATE = 5;
    localparam int IDX_MON  = 6;
    localparam int IDX_YEAR = 7;

    typedef enum logic [1:0] {
        ST_RUN,
        ST_RHOLD,
        ST_WHOLD,
        ST_COMMIT
    } rtc_state_e;

    function automatic logic [BYTE_W-1:0] field_mask(input int idx);
        case (idx)
            IDX_CTRL: field_mask = 8'h3F;
            IDX_SEC:  field_mask = 8'h7F;
            IDX_MIN:  field_mask = 8'h7F;
            IDX_HOUR: field_mask = 8'h3F;
            IDX_DAY:  field_mask = 8'h07;
            IDX_DATE: field_mask = 8'h3F;
            IDX_MON:  field_mask = 8'h1F;
            default:  field_mask = 8'hFF;
        endcase
    endfunction
endpackage

// File: rtl/rtc_addr_decode.sv
module rtc_addr_decode
    import rtc_pkg::*;
#(
    parameter int ADDR_W = 19
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              cs_n,
    input  logic              we_n,
    input  logic              oe_n,
    output logic [IDX_W-1:0]  idx,
    output logic              clk_wr,
    output logic              clk_rd,
    output logic              ram_cs,
    output logic              ram_we,
    output logic              ram_oe
);
    logic hit;
    logic sel;

    always_comb begin
        hit    = &addr[ADDR_W-1:IDX_W];
        sel    = !cs_n;
        idx    = addr[IDX_W-1:0];
        clk_wr = sel && hit && !we_n;
        clk_rd = sel && hit && we_n && !oe_n;
        ram_cs = sel && !hit;
        ram_we = ram_cs && !we_n;
        ram_oe = ram_cs && we_n && !oe_n;
    end
endmodule

// File: rtl/rtc_ctrl_fsm.sv
module rtc_ctrl_fsm
    import rtc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ctrl_wr,
    input  logic wr_hold,
    input  logic rd_hold,
    input  logic tick,
    output logic refresh,
    output logic frozen,
    output logic commit,
    output logic wbit,
    output logic rbit
);
    rtc_state_e state_q, state_d;
    logic       rbit_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            rbit_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (ctrl_wr) rbit_q <= rd_hold;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN, ST_RHOLD: begin
                if (ctrl_wr) begin
                    if (wr_hold)      state_d = ST_WHOLD;
                    else if (rd_hold) state_d = ST_RHOLD;
                    else              state_d = ST_RUN;
                end
            end
            ST_WHOLD: begin
                if (ctrl_wr && !wr_hold) state_d = ST_COMMIT;
            end
            ST_COMMIT: begin
                if (ctrl_wr && wr_hold)      state_d = ST_WHOLD;
                else if (ctrl_wr)            state_d = rd_hold ? ST_RHOLD : ST_RUN;
                else                         state_d = rbit_q ? ST_RHOLD : ST_RUN;
            end
        endcase
    end

    always_comb begin
        refresh = tick && (state_q == ST_RUN);
        frozen  = (state_q != ST_RUN);
        commit  = (state_q == ST_COMMIT);
        wbit    = (state_q == ST_WHOLD);
        rbit    = rbit_q;
    end
endmodule

// File: rtl/rtc_shadow_regs.sv
module rtc_shadow_regs
    import rtc_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr,
    input  logic [IDX_W-1:0]       idx,
    input  logic [BYTE_W-1:0]      wdata,
    input  logic                   refresh,
    input  logic [NREG*BYTE_W-1:0] cnt_in,
    input  logic                   batt_ok,
    input  logic                   sq512,
    input  logic                   wbit,
    input  logic                   rbit,
    output logic [NREG*BYTE_W-1:0] vis_flat,
    output logic                   osc_q,
    output logic [BYTE_W-1:0]      rd_byte
);
    logic [BYTE_W-1:0] vis [NREG];
    logic              ft_q;

    for (genvar i = 0; i < NREG; i++) begin : g_byte
        localparam logic [BYTE_W-1:0] MASK = field_mask(i);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                vis[i] <= '0;
            else if (wr && (idx == IDX_W'(i)))
                vis[i] <= wdata & MASK;
            else if (refresh)
                vis[i] <= cnt_in[i*BYTE_W +: BYTE_W] & MASK;
        end
        assign vis_flat[i*BYTE_W +: BYTE_W] = vis[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            osc_q <= 1'b0;
            ft_q  <= 1'b0;
        end else if (wr) begin
            if (idx == IDX_W'(IDX_SEC)) osc_q <= wdata[7];
            if (idx == IDX_W'(IDX_DAY)) ft_q  <= wdata[6];
        end
    end

    always_comb begin
        rd_byte = vis[idx];
        case (idx)
            IDX_W'(IDX_CTRL): rd_byte = {wbit, rbit, vis[IDX_CTRL][5:0]};
            IDX_W'(IDX_SEC):  rd_byte = {osc_q, vis[IDX_SEC][6:1],
                                         (ft_q && !osc_q) ? sq512 : vis[IDX_SEC][0]};
            IDX_W'(IDX_DAY):  rd_byte = {batt_ok, ft_q, vis[IDX_DAY][5:0]};
            default:          rd_byte = vis[idx];
        endcase
    end
endmodule

// File: rtl/rtc_regfile.sv
module rtc_regfile
    import rtc_pkg::*;
#(
    parameter int ADDR_W = 19
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [ADDR_W-1:0]      addr,
    input  logic [7:0]             wdata,
    input  logic                   cs_n,
    input  logic                   we_n,
    input  logic                   oe_n,
    output logic [7:0]             rdata,
    input  logic [7:0]             ram_rdata,
    output logic                   ram_cs,
    output logic                   ram_we,
    output logic                   ram_oe,
    input  logic                   tick,
    input  logic [63:0]            cnt_in,
    output logic                   cnt_load,
    output logic [63:0]            cnt_load_data,
    output logic                   osc_stop,
    input  logic                   sq512,
    input  logic                   batt_ok
);
    logic [IDX_W-1:0]       idx;
    logic                   clk_wr, clk_rd;
    logic                   refresh, frozen, commit, wbit, rbit;
    logic [NREG*BYTE_W-1:0] vis_flat;
    logic [BYTE_W-1:0]      rd_byte;
    logic                   ctrl_wr;

    rtc_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr(addr), .cs_n(cs_n), .we_n(we_n), .oe_n(oe_n),
        .idx(idx), .clk_wr(clk_wr), .clk_rd(clk_rd),
        .ram_cs(ram_cs), .ram_we(ram_we), .ram_oe(ram_oe)
    );

    assign ctrl_wr = clk_wr && (idx == IDX_W'(IDX_CTRL));

    rtc_ctrl_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr),
        .wr_hold(wdata[7]), .rd_hold(wdata[6]), .tick(tick),
        .refresh(refresh), .frozen(frozen), .commit(commit),
        .wbit(wbit), .rbit(rbit)
    );

    rtc_shadow_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr(clk_wr), .idx(idx), .wdata(wdata),
        .refresh(refresh), .cnt_in(cnt_in), .batt_ok(batt_ok), .sq512(sq512),
        .wbit(wbit), .rbit(rbit), .vis_flat(vis_flat), .osc_q(osc_stop),
        .rd_byte(rd_byte)
    );

    always_comb begin
        if (clk_rd)      rdata = rd_byte;
        else if (ram_oe) rdata = ram_rdata;
        else             rdata = '0;
        cnt_load      = commit;
        cnt_load_data = vis_flat;
    end
endmodule

// File: rtl/rtc_regfile_chk.sv
module rtc_regfile_chk #(
    parameter int ADDR_W = 19
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic [7:0]        wdata,
    input logic              cs_n,
    input logic              we_n,
    input logic              oe_n,
    input logic [7:0]        rdata,
    input logic              ram_cs,
    input logic              ram_we,
    input logic              cnt_load,
    input logic              osc_stop,
    input logic              batt_ok,
    input logic              frozen,
    input logic [63:0]       vis_flat
);
    localparam logic [ADDR_W-1:0] A_CTRL = {ADDR_W{1'b1}} - ADDR_W'(7);
    localparam logic [ADDR_W-1:0] A_SEC  = A_CTRL + ADDR_W'(1);
    localparam logic [ADDR_W-1:0] A_DAY  = A_CTRL + ADDR_W'(4);

    logic bus_wr;
    assign bus_wr = !cs_n && !we_n;

    assert_clk_space_not_ram_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && (&addr[ADDR_W-1:3])) |-> (!ram_cs && !ram_we));

    assert_idle_bus_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> (rdata == 8'h00 && !ram_cs));

    assert_frozen_copy_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (frozen && !bus_wr) |=> $stable(vis_flat));

    assert_load_after_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_load |-> $past(bus_wr && addr == A_CTRL && !wdata[7]));

    assert_load_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_load |=> !cnt_load);

    assert_osc_only_by_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bus_wr && addr == A_SEC) |-> $stable(osc_stop));

    assert_batt_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !oe_n && we_n && addr == A_DAY) |-> (rdata[7] == batt_ok));
endmodule

bind rtc_regfile rtc_regfile_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_rtc_regfile.sv
module sim_rtc_regfile;
    localparam int ADDR_W = 19;
    localparam logic [18:0] BASE = 19'h7FFF8;

    logic        clk = 0, rst_n = 0;
    logic [18:0] addr = '0;
    logic [7:0]  wdata = '0, ram_rdata = '0;
    logic        cs_n = 1, we_n = 1, oe_n = 1, tick = 0, sq512 = 0, batt_ok = 1;
    logic [63:0] cnt_in = 64'h99_12_31_05_23_34_59_20;
    logic [7:0]  rdata;
    logic        ram_cs, ram_we, ram_oe, cnt_load, osc_stop;
    logic [63:0] cnt_load_data;
    int          errors = 0, checks = 0;

    always #2 clk = ~clk;

    rtc_regfile #(.ADDR_W(ADDR_W)) u0 (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .cs_n(cs_n),
        .we_n(we_n), .oe_n(oe_n), .rdata(rdata), .ram_rdata(ram_rdata),
        .ram_cs(ram_cs), .ram_we(ram_we), .ram_oe(ram_oe), .tick(tick),
        .cnt_in(cnt_in), .cnt_load(cnt_load), .cnt_load_data(cnt_load_data),
        .osc_stop(osc_stop), .sq512(sq512), .batt_ok(batt_ok)
    );

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [18:0] a, input logic [7:0] d, input logic oe = 1'b1);
        @(negedge clk);
        addr = a; wdata = d; cs_n = 0; we_n = 0; oe_n = oe;
        @(negedge clk);
        cs_n = 1; we_n = 1; oe_n = 1;
    endtask

    task automatic rd(input logic [18:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        addr = a; cs_n = 0; we_n = 1; oe_n = 0;
        #1 chk(tag, {56'd0, rdata}, {56'd0, exp});
        cs_n = 1; oe_n = 1;
    endtask

    task automatic pulse_tick();
        @(negedge clk); tick = 1;
        @(negedge clk); tick = 0;
    endtask

    // op: 0 tick, 1 write, 2 read-check ; {op, idx, data, expected}
    localparam int NV = 22;
    localparam logic [20:0] VEC [NV] = '{
        {2'd0, 3'd0, 8'h00, 8'h00},
        {2'd2, 3'd1, 8'h00, 8'h59},
        {2'd2, 3'd0, 8'h00, 8'h20},
        {2'd2, 3'd4, 8'h00, 8'h85},
        {2'd2, 3'd6, 8'h00, 8'h12},
        {2'd2, 3'd7, 8'h00, 8'h99},
        {2'd1, 3'd2, 8'h11, 8'h00},
        {2'd2, 3'd2, 8'h00, 8'h11},
        {2'd0, 3'd0, 8'h00, 8'h00},
        {2'd2, 3'd2, 8'h00, 8'h34},
        {2'd1, 3'd4, 8'hFF, 8'h00},
        {2'd2, 3'd4, 8'h00, 8'hC7},
        {2'd1, 3'd4, 8'h05, 8'h00},
        {2'd2, 3'd4, 8'h00, 8'h85},
        {2'd1, 3'd7, 8'h42, 8'h00},
        {2'd2, 3'd7, 8'h00, 8'h42},
        {2'd1, 3'd6, 8'hFF, 8'h00},
        {2'd2, 3'd6, 8'h00, 8'h1F},
        {2'd1, 3'd3, 8'hFF, 8'h00},
        {2'd2, 3'd3, 8'h00, 8'h3F},
        {2'd1, 3'd5, 8'hFF, 8'h00},
        {2'd2, 3'd5, 8'h00, 8'h3F}
    };

    initial begin
        #800000;
        errors++; checks++;
        $display("FAIL watchdog R11: actual=hang expected=finish");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R11 reset state
        chk("R11 osc_stop", {63'd0, osc_stop}, 64'd0);
        chk("R11 cnt_load", {63'd0, cnt_load}, 64'd0);
        rd(BASE + 0, 8'h00, "R11 control byte");
        rd(BASE + 1, 8'h00, "R11 seconds");
        rd(BASE + 4, 8'h80, "R11 weekday with R9 flag");

        // R1 R3 R8 R9 R10 vector walk
        for (int i = 0; i < NV; i++) begin
            logic [1:0] op = VEC[i][20:19];
            logic [2:0] ix = VEC[i][18:16];
            if (op == 2'd0) pulse_tick();
            else if (op == 2'd1) wr(BASE + 19'(ix), VEC[i][15:8]);
            else rd(BASE + 19'(ix), VEC[i][7:0], $sformatf("R1/R3/R10 vector %0d", i));
        end

        // R4 read hold, R5 release
        wr(BASE + 0, 8'h40);
        cnt_in[15:8] = 8'h10;
        pulse_tick();
        rd(BASE + 1, 8'h59, "R4 seconds frozen");
        rd(BASE + 0, 8'h40, "R4 read bit readback");
        chk("R4 no load", {63'd0, cnt_load}, 64'd0);
        wr(BASE + 0, 8'h00);
        rd(BASE + 1, 8'h59, "R5 held until tick");
        pulse_tick();
        rd(BASE + 1, 8'h10, "R5 refreshed");
        rd(BASE + 0, 8'h20, "R5 century refreshed");

        // R6 write hold and commit
        wr(BASE + 0, 8'h80);
        rd(BASE + 0, 8'h80, "R6 write bit readback");
        wr(BASE + 1, 8'h07);
        pulse_tick();
        rd(BASE + 1, 8'h07, "R6 loaded value held");
        wr(BASE + 0, 8'h15);
        chk("R6 load pulse", {63'd0, cnt_load}, 64'd1);
        chk("R6 load century", {56'd0, cnt_load_data[7:0]}, 64'h15);
        chk("R6 load seconds", {56'd0, cnt_load_data[15:8]}, 64'h07);
        chk("R6 load year", {56'd0, cnt_load_data[63:56]}, 64'h99);
        @(negedge clk);
        chk("R6 load single", {63'd0, cnt_load}, 64'd0);

        // R7 oscillator stop, R8 frequency test
        wr(BASE + 1, 8'h80);
        chk("R7 osc_stop", {63'd0, osc_stop}, 64'd1);
        rd(BASE + 1, 8'h80, "R7 readback");
        sq512 = 1;
        wr(BASE + 4, 8'h40);
        rd(BASE + 1, 8'h80, "R8 no toggle while stopped");
        wr(BASE + 1, 8'h00);
        rd(BASE + 1, 8'h01, "R8 sq512 high");
        sq512 = 0;
        rd(BASE + 1, 8'h00, "R8 sq512 low");

        // R2 strobes
        @(negedge clk);
        addr = BASE + 7; cs_n = 0; we_n = 1; oe_n = 1;
        #1 chk("R2 no read without oe", {56'd0, rdata}, 64'd0);
        cs_n = 1;
        wr(BASE + 2, 8'h27, 1'b0);
        rd(BASE + 2, 8'h27, "R2 write wins over oe");

        // R1 RAM pass-through
        ram_rdata = 8'hA5;
        @(negedge clk);
        addr = 19'h12345; cs_n = 0; we_n = 1; oe_n = 0;
        #1 chk("R1 ram read data", {56'd0, rdata}, 64'hA5);
        chk("R1 ram_cs", {63'd0, ram_cs}, 64'd1);
        cs_n = 1; oe_n = 1;
        @(negedge clk);
        addr = 19'h7FFF7; wdata = 8'h00; cs_n = 0; we_n = 0;
        #1 chk("R1 ram write strobe", {63'd0, ram_we}, 64'd1);
        @(negedge clk);
        cs_n = 1; we_n = 1;
        rd(BASE + 7, 8'h99, "R1 clock byte untouched by ram write");

        // R9 battery flag
        batt_ok = 0;
        rd(BASE + 4, 8'h40, "R9 flag low");
        wr(BASE + 4, 8'h80);
        rd(BASE + 4, 8'h00, "R9 flag not writable");

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule